// File: doc/BRIEF.md
# DQS Delay Window Calibration Sequencer

This block is a sequencer that finds the read strobe delay setting of a DDR memory interface at which data capture is most reliable. It works on one byte lane or on two. Each lane has an 8-bit delay field that holds a coarse step count in its upper nibble and a fine step count in its lower nibble. For each lane the sequencer walks the delay up until a read test fails, then down until one fails, at both coarse and fine resolution. It then programs the midpoint of the window it found.

The block does not exercise memory itself. An external tester takes a candidate delay word over a request/acknowledge handshake and reports pass or fail with its acknowledge. The bottom of the downward search is clamped by a value read from the delay-locked loop. That value is sampled, together with the bus width, when calibration starts. While a calibration is in progress the sequencer drives controls that hold off automatic self-refresh and clear the strobe gating window of every lane under calibration. It releases both controls in the same cycle that it presents the final word and pulses done.

Top module: `dqs_cal_seq`

## Requirements
- R1: Lane 0 uses bits 7:0 of the delay word and lane 1 uses bits 15:8. Within a lane, bits 7:4 hold the coarse count and bits 3:0 hold the fine count. At start both lanes are preset to coarse 7 and fine 4 (field 0x74). A lane that is not calibrated keeps 0x74 in every trial word and in the result.
- R2: Upward coarse search: the fine field is held at 15 and coarse steps from 7 up to 15. On the first fail at coarse value v, the upper coarse edge is v-1, or 7 if v is 7. If no trial fails, the edge is 15.
- R3: Upward fine search: coarse is held at the upper coarse edge and fine steps from 0 up to 15. Let t be v-1 (or 0 if v is 0) on the first fail at v, and 15 if no trial fails. If t is 0, the upper fine edge is 15 and the upper coarse edge drops by one. Otherwise the upper fine edge is t-1.
- R4: Downward coarse search: the fine field is 0 and coarse steps from 6 down to a limit. The limit is 8 minus dll_tap[7:4] when that nibble is below 8, and 0 otherwise. On the first fail at v, the lower coarse edge is v+1, or 6 if v is 6. With no fail the edge is the limit. If the limit is above 6, no coarse trial is made and the edge is 6.
- R5: Downward fine search: coarse is held at the lower coarse edge and fine steps from 15 down to a limit computed in the same way from dll_tap[3:0]. A fail at 15 sets the lower fine edge to 0 and raises the lower coarse edge by one. A fail at any other v gives v+1. With no fail the edge is the limit.
- R6: Let S be the sum of the two coarse edges. The centre coarse value is S>>1. The centre fine value is 4*(S mod 2) plus (sum of the fine edges)>>1. A centre fine value of 16 or more is reduced by 16 and the centre coarse value is raised by one.
- R7: With wide_bus low at start only lane 0 is calibrated. With it high lane 0 is calibrated and then lane 1. Lane 1's trials carry lane 0's centre field.
- R8: trial_req stays high with a stable trial_word until a cycle in which trial_ack is high. It is low in the following cycle. trial_fail is used only in cycles in which trial_ack is high.
- R9: sr_hold and gate_clr[0] are high from the cycle after start until done. gate_clr[1] does the same only when wide_bus was high at start. All of them are low in the done cycle.
- R10: done is a one-cycle pulse. result takes the final word in that same cycle and changes at no other time. After reset, result, done, trial_req, sr_hold and gate_clr are all zero.
- R11: A start, wide_bus or dll_tap change during a calibration has no effect. The run finishes with the values sampled at its own start, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a calibration (taken while idle) |
| wide_bus | input | 1 | 1: calibrate both lanes, 0: lane 0 only |
| dll_tap | input | 8 | DLL tap value; high nibble limits coarse, low nibble limits fine |
| trial_req | output | 1 | Trial request to the memory tester |
| trial_word | output | 16 | Candidate delay word for the trial |
| trial_ack | input | 1 | Tester acknowledge, one cycle |
| trial_fail | input | 1 | Trial result, valid with trial_ack |
| sr_hold | output | 1 | Suppress automatic self-refresh |
| gate_clr | output | 2 | Clear the strobe gating window, one bit per lane |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Final calibrated delay word |

## Verification
The tester model scores each lane with a delay of coarse times a random step plus fine. Some runs reverse the fine direction. This produces fails exactly at the seed of a fine search, which forces the coarse adjustments of R3 and R5, and odd coarse sums whose fine centre wraps past 15. A design that mishandled any of these would be off by one coarse step or by sixteen fine steps in the result. Directed runs use a DLL tap of 0, where the downward coarse search must be skipped entirely. A design that still searched would issue extra trials and return a lower edge of 8. Other directed runs use a tap of 0xFF, where the search must reach 0. Trial counts and per-trial checks catch a request held into a second acknowledge, an uncalibrated lane that loses its 0x74 preset, and a start pulse mid-run that would be queued or would switch the bus width.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LANE,
    ST_REQ,
    ST_STEP,
    ST_CENTRE,
    ST_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    PH_CMAX,
    PH_FMAX,
    PH_CMIN,
    PH_FMIN,
    PH_END
  } srch_phase_t;

endpackage

// File: rtl/dqs_cal_rst_sync.sv
module dqs_cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain <= '0;
    else           chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain[STAGES-1];
endmodule

// File: rtl/dqs_cal_limit.sv
// Lower search bound from one DLL tap nibble (R4, R5).
module dqs_cal_limit #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] tap,
  output logic [NIB_W-1:0] limit
);
  localparam int THRESH = 2 ** (NIB_W - 1);

  always_comb begin
    if (int'(tap) < THRESH) limit = NIB_W'(THRESH - int'(tap));
    else                    limit = '0;
  end
endmodule

// File: rtl/dqs_cal_centre.sv
// Window midpoint with the odd coarse half-step carried into fine (R6).
module dqs_cal_centre #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0]   c_hi,
  input  logic [NIB_W-1:0]   c_lo,
  input  logic [NIB_W-1:0]   f_hi,
  input  logic [NIB_W-1:0]   f_lo,
  output logic [2*NIB_W-1:0] field
);
  localparam int FINE_SPAN = 2 ** NIB_W;
  localparam logic [NIB_W:0]   HALF_STEP = (NIB_W+1)'(2 ** (NIB_W - 2));
  localparam logic [NIB_W-1:0] ONE = NIB_W'(1);

  logic [NIB_W:0]   c_sum;
  logic [NIB_W:0]   f_sum;
  logic [NIB_W:0]   fine_raw;
  logic [NIB_W-1:0] c_mid;
  logic [NIB_W-1:0] f_mid;

  always_comb begin
    c_sum    = {1'b0, c_hi} + {1'b0, c_lo};
    f_sum    = {1'b0, f_hi} + {1'b0, f_lo};
    fine_raw = (c_sum[0] ? HALF_STEP : '0) + {1'b0, f_sum[NIB_W:1]};
    c_mid    = c_sum[NIB_W:1];
    f_mid    = fine_raw[NIB_W-1:0];
    if (int'(fine_raw) >= FINE_SPAN) c_mid = c_mid + ONE;
    field = {c_mid, f_mid};
  end
endmodule

// File: rtl/dqs_cal_fsm.sv
module dqs_cal_fsm
  import dqs_cal_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int LANES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       wide_bus,
  input  logic [2*NIB_W-1:0]         dll_tap,
  input  logic                       trial_ack,
  input  logic                       trial_fail,
  input  logic [2*NIB_W-1:0]         centre_field,
  input  logic [NIB_W-1:0]           c_limit,
  input  logic [NIB_W-1:0]           f_limit,
  output logic                       trial_req,
  output logic [LANES*2*NIB_W-1:0]   trial_word,
  output logic                       sr_hold,
  output logic [LANES-1:0]           gate_clr,
  output logic                       done,
  output logic [LANES*2*NIB_W-1:0]   result,
  output logic [NIB_W-1:0]           c_hi,
  output logic [NIB_W-1:0]           c_lo,
  output logic [NIB_W-1:0]           f_hi,
  output logic [NIB_W-1:0]           f_lo,
  output logic [2*NIB_W-1:0]         dll_q
);
  localparam int FW     = 2 * NIB_W;
  localparam int W      = LANES * FW;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  localparam logic [NIB_W-1:0] N_MAX = {NIB_W{1'b1}};
  localparam logic [NIB_W-1:0] N_ZERO = '0;
  localparam logic [NIB_W-1:0] ONE   = NIB_W'(1);
  localparam logic [NIB_W-1:0] CUP   = NIB_W'(2 ** (NIB_W - 1) - 1);
  localparam logic [NIB_W-1:0] CDN   = NIB_W'(2 ** (NIB_W - 1) - 2);
  localparam logic [NIB_W-1:0] FUP   = N_ZERO;
  localparam logic [NIB_W-1:0] FDN   = N_MAX;
  localparam logic [NIB_W-1:0] FPRE  = NIB_W'(2 ** (NIB_W - 2));
  localparam logic [FW-1:0]    PRESET_FIELD = {CUP, FPRE};
  localparam logic [W-1:0]     PRESET_WORD  = {LANES{PRESET_FIELD}};
  localparam logic [LANE_W-1:0] LANE_ONE  = LANE_W'(1);
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

  seq_state_t        state, state_d;
  srch_phase_t       phase, phase_d;
  logic [NIB_W-1:0]  cur, cur_d;
  logic [NIB_W-1:0]  cmax, cmax_d, cmin, cmin_d, fmax, fmax_d, fmin, fmin_d;
  logic [LANE_W-1:0] lane, lane_d;
  logic [W-1:0]      base, base_d, res, res_d;
  logic              wide_q, wide_d;
  logic [FW-1:0]     dll_d;
  logic [NIB_W-1:0]  fine_t;
  logic [FW-1:0]     trial_field;
  logic [LANE_W-1:0] last_lane;

  function automatic logic [W-1:0] put_field(input logic [W-1:0]      w,
                                             input logic [LANE_W-1:0] idx,
                                             input logic [FW-1:0]     f);
    logic [W-1:0] r;
    r = w;
    for (int l = 0; l < LANES; l++) begin
      if (LANE_W'(l) == idx) r[l*FW +: FW] = f;
    end
    return r;
  endfunction

  assign last_lane = wide_q ? LANE_LAST : '0;

  // Candidate field for the running phase
  always_comb begin
    unique case (phase)
      PH_CMAX: trial_field = {cur, N_MAX};
      PH_FMAX: trial_field = {cmax, cur};
      PH_CMIN: trial_field = {cur, N_ZERO};
      PH_FMIN: trial_field = {cmin, cur};
      default: trial_field = PRESET_FIELD;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d = state;
    phase_d = phase;
    cur_d   = cur;
    cmax_d  = cmax;
    cmin_d  = cmin;
    fmax_d  = fmax;
    fmin_d  = fmin;
    lane_d  = lane;
    base_d  = base;
    res_d   = res;
    wide_d  = wide_q;
    dll_d   = dll_q;
    fine_t  = '0;

    unique case (state)
      ST_IDLE: begin
        if (start) begin
          wide_d  = wide_bus;
          dll_d   = dll_tap;
          base_d  = PRESET_WORD;
          lane_d  = '0;
          state_d = ST_LANE;
        end
      end

      ST_LANE: begin
        phase_d = PH_CMAX;
        cur_d   = CUP;
        state_d = ST_REQ;
      end

      ST_REQ: begin
        if (trial_ack) begin
          state_d = ST_STEP;
          unique case (phase)
            PH_CMAX: begin
              if (trial_fail || cur == N_MAX) begin
                if (!trial_fail)    cmax_d = N_MAX;
                else if (cur == CUP) cmax_d = CUP;
                else                cmax_d = cur - ONE;
                phase_d = PH_FMAX;
                cur_d   = FUP;
              end else begin
                cur_d = cur + ONE;
              end
            end
            PH_FMAX: begin
              if (trial_fail || cur == N_MAX) begin
                if (!trial_fail)    fine_t = N_MAX;
                else if (cur == FUP) fine_t = FUP;
                else                fine_t = cur - ONE;
                if (fine_t == FUP) begin
                  fmax_d = N_MAX;
                  cmax_d = cmax - ONE;
                end else begin
                  fmax_d = fine_t - ONE;
                end
                phase_d = PH_CMIN;
                cur_d   = CDN;
              end else begin
                cur_d = cur + ONE;
              end
            end
            PH_CMIN: begin
              if (trial_fail || cur == c_limit) begin
                if (!trial_fail)    cmin_d = c_limit;
                else if (cur == CDN) cmin_d = CDN;
                else                cmin_d = cur + ONE;
                phase_d = PH_FMIN;
                cur_d   = FDN;
              end else begin
                cur_d = cur - ONE;
              end
            end
            PH_FMIN: begin
              if (trial_fail || cur == f_limit) begin
                if (!trial_fail) begin
                  fmin_d = f_limit;
                end else if (cur == FDN) begin
                  fmin_d = N_ZERO;
                  cmin_d = cmin + ONE;
                end else begin
                  fmin_d = cur + ONE;
                end
                phase_d = PH_END;
              end else begin
                cur_d = cur - ONE;
              end
            end
            default: ;
          endcase
        end
      end

      ST_STEP: begin
        if (phase == PH_END) begin
          state_d = ST_CENTRE;
        end else begin
          if (phase == PH_CMIN && c_limit > CDN) begin
            cmin_d  = CDN;
            phase_d = PH_FMIN;
            cur_d   = FDN;
          end
          state_d = ST_REQ;
        end
      end

      ST_CENTRE: begin
        base_d = put_field(base, lane, centre_field);
        if (lane == last_lane) begin
          res_d   = put_field(base, lane, centre_field);
          state_d = ST_DONE;
        end else begin
          lane_d  = lane + LANE_ONE;
          state_d = ST_LANE;
        end
      end

      ST_DONE: state_d = ST_IDLE;

      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= PH_CMAX;
      cur    <= '0;
      cmax   <= '0;
      cmin   <= '0;
      fmax   <= '0;
      fmin   <= '0;
      lane   <= '0;
      base   <= '0;
      res    <= '0;
      wide_q <= 1'b0;
      dll_q  <= '0;
    end else begin
      state  <= state_d;
      phase  <= phase_d;
      cur    <= cur_d;
      cmax   <= cmax_d;
      cmin   <= cmin_d;
      fmax   <= fmax_d;
      fmin   <= fmin_d;
      lane   <= lane_d;
      base   <= base_d;
      res    <= res_d;
      wide_q <= wide_d;
      dll_q  <= dll_d;
    end
  end

  // Outputs
  assign trial_req  = (state == ST_REQ);
  assign trial_word = put_field(base, lane, trial_field);
  assign sr_hold    = (state != ST_IDLE) && (state != ST_DONE);
  assign done       = (state == ST_DONE);
  assign result     = res;
  assign c_hi       = cmax;
  assign c_lo       = cmin;
  assign f_hi       = fmax;
  assign f_lo       = fmin;

  always_comb begin
    gate_clr    = '0;
    gate_clr[0] = sr_hold;
    for (int l = 1; l < LANES; l++) gate_clr[l] = sr_hold & wide_q;
  end
endmodule

// File: rtl/dqs_cal_seq.sv
module dqs_cal_seq #(
  parameter int NIB_W = 4,
  parameter int LANES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     wide_bus,
  input  logic [2*NIB_W-1:0]       dll_tap,
  output logic                     trial_req,
  output logic [LANES*2*NIB_W-1:0] trial_word,
  input  logic                     trial_ack,
  input  logic                     trial_fail,
  output logic                     sr_hold,
  output logic [LANES-1:0]         gate_clr,
  output logic                     done,
  output logic [LANES*2*NIB_W-1:0] result
);
  localparam int FW = 2 * NIB_W;

  logic             rst_n_s;
  logic [FW-1:0]    centre_field;
  logic [NIB_W-1:0] c_limit, f_limit;
  logic [NIB_W-1:0] c_hi, c_lo, f_hi, f_lo;
  logic [FW-1:0]    dll_q;

  dqs_cal_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  dqs_cal_limit #(.NIB_W(NIB_W)) u_lim_coarse (
    .tap   (dll_q[FW-1:NIB_W]),
    .limit (c_limit)
  );

  dqs_cal_limit #(.NIB_W(NIB_W)) u_lim_fine (
    .tap   (dll_q[NIB_W-1:0]),
    .limit (f_limit)
  );

  dqs_cal_centre #(.NIB_W(NIB_W)) u_centre (
    .c_hi  (c_hi),
    .c_lo  (c_lo),
    .f_hi  (f_hi),
    .f_lo  (f_lo),
    .field (centre_field)
  );

  dqs_cal_fsm #(.NIB_W(NIB_W), .LANES(LANES)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start        (start),
    .wide_bus     (wide_bus),
    .dll_tap      (dll_tap),
    .trial_ack    (trial_ack),
    .trial_fail   (trial_fail),
    .centre_field (centre_field),
    .c_limit      (c_limit),
    .f_limit      (f_limit),
    .trial_req    (trial_req),
    .trial_word   (trial_word),
    .sr_hold      (sr_hold),
    .gate_clr     (gate_clr),
    .done         (done),
    .result       (result),
    .c_hi         (c_hi),
    .c_lo         (c_lo),
    .f_hi         (f_hi),
    .f_lo         (f_lo),
    .dll_q        (dll_q)
  );
endmodule

// File: rtl/dqs_cal_seq_chk.sv
module dqs_cal_seq_chk #(
  parameter int W     = 16,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trial_req,
  input logic [W-1:0]     trial_word,
  input logic             trial_ack,
  input logic             sr_hold,
  input logic [LANES-1:0] gate_clr,
  input logic             done,
  input logic [W-1:0]     result
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req && !trial_ack |=> trial_req && $stable(trial_word)); // R8
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req && trial_ack |=> !trial_req); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req |-> sr_hold && gate_clr[0]); // R9
  AST_GATE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    gate_clr[LANES-1] |-> sr_hold); // R9
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sr_hold && !trial_req); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_RESULT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done); // R10
endmodule

bind dqs_cal_seq dqs_cal_seq_chk #(.W(LANES*2*NIB_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trial_req  (trial_req),
  .trial_word (trial_word),
  .trial_ack  (trial_ack),
  .sr_hold    (sr_hold),
  .gate_clr   (gate_clr),
  .done       (done),
  .result     (result)
);

// File: tb/dqs_cal_seq_bench.sv
`timescale 1ns/1ps
module dqs_cal_seq_bench;
  logic        clk, rst_n, start, wide_bus, trial_req, trial_ack, trial_fail;
  logic        sr_hold, done;
  logic [7:0]  dll_tap;
  logic [15:0] trial_word, result;
  logic [1:0]  gate_clr;

  dqs_cal_seq u_dqs_cal_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_bus(wide_bus), .dll_tap(dll_tap),
    .trial_req(trial_req), .trial_word(trial_word), .trial_ack(trial_ack),
    .trial_fail(trial_fail), .sr_hold(sr_hold), .gate_clr(gate_clr),
    .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  // tester environment
  bit   wd_g, inv_g;
  logic [7:0] dll_g;
  int   step_g;
  int   lo_g[2], hi_g[2];
  int   ntr, hold_bad, preset_bad, gap;
  bit   tester_on;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] put_f(logic [15:0] w, int ln, int c, int f);
    logic [15:0] r;
    r = w;
    r[ln*8 +: 8] = {4'(c), 4'(f)};
    return r;
  endfunction

  function automatic bit tpass(logic [15:0] w);
    for (int l = 0; l < 2; l++) begin
      int c, f, d;
      if (l == 1 && !wd_g) continue;
      c = int'(w[l*8+4 +: 4]);
      f = int'(w[l*8 +: 4]);
      d = c * step_g + (inv_g ? 15 - f : f);
      if (d < lo_g[l] || d > hi_g[l]) return 1'b0;
    end
    return 1'b1;
  endfunction

  // Reference calibration from R1-R7 rules (R2 R3 R4 R5 R6 R7)
  task automatic ref_cal(output logic [15:0] res, output int nt);
    logic [15:0] base;
    int cmax, fmax, cmin, fmin, t, cl, fl, cs, cc, fc, nl;
    base = 16'h7474;
    nt = 0;
    nl = wd_g ? 2 : 1;
    cl = (int'(dll_g[7:4]) < 8) ? 8 - int'(dll_g[7:4]) : 0;
    fl = (int'(dll_g[3:0]) < 8) ? 8 - int'(dll_g[3:0]) : 0;
    for (int ln = 0; ln < nl; ln++) begin
      cmax = 15;
      for (int v = 7; v <= 15; v++) begin
        nt++;
        if (!tpass(put_f(base, ln, v, 15))) begin cmax = (v == 7) ? 7 : v - 1; break; end
      end
      t = 15;
      for (int v = 0; v <= 15; v++) begin
        nt++;
        if (!tpass(put_f(base, ln, cmax, v))) begin t = (v == 0) ? 0 : v - 1; break; end
      end
      if (t == 0) begin fmax = 15; cmax--; end else fmax = t - 1;
      if (cl > 6) cmin = 6;
      else begin
        cmin = cl;
        for (int v = 6; v >= cl; v--) begin
          nt++;
          if (!tpass(put_f(base, ln, v, 0))) begin cmin = (v == 6) ? 6 : v + 1; break; end
        end
      end
      fmin = fl;
      for (int v = 15; v >= fl; v--) begin
        nt++;
        if (!tpass(put_f(base, ln, cmin, v))) begin
          if (v == 15) begin fmin = 0; cmin++; end else fmin = v + 1;
          break;
        end
      end
      cs = cmax + cmin;
      cc = cs / 2;
      fc = 4 * (cs % 2) + (fmax + fmin) / 2;
      if (fc >= 16) begin fc -= 16; cc++; end
      base = put_f(base, ln, cc, fc);
    end
    res = base;
  endtask

  // Memory tester model: acknowledges after a random gap; trial_fail is noise when no ack (R8)
  always @(negedge clk) begin
    if (trial_ack) begin
      trial_ack  = 1'b0;
      trial_fail = 1'($urandom % 2);
    end else if (trial_req && tester_on) begin
      if (gap == 0) begin
        trial_ack  = 1'b1;
        trial_fail = !tpass(trial_word);
        ntr++;
        if (!sr_hold || gate_clr != {wd_g, 1'b1}) hold_bad++;
        if (!wd_g && trial_word[15:8] != 8'h74) preset_bad++;
        gap = $urandom % 3;
      end else begin
        gap--;
      end
    end
  end

  task automatic set_env(input int step, input bit inv, input int lo0, input int hi0);
    int p;
    step_g = step; inv_g = inv; lo_g[0] = lo0; hi_g[0] = hi0;
    p = 7 * step + (inv ? 11 : 4);
    lo_g[1] = p - int'($urandom % 50);
    hi_g[1] = p + int'($urandom % 50);
  endtask

  task automatic run_cal(input bit wd, input logic [7:0] dll, input bit poke, input string tag);
    logic [15:0] exp;
    int ent, cyc;
    bit extra;
    wd_g = wd; dll_g = dll;
    ref_cal(exp, ent);
    ntr = 0; hold_bad = 0; preset_bad = 0; gap = 0;
    @(negedge clk);
    wide_bus = wd; dll_tap = dll; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(sr_hold == 1'b1 && gate_clr == {wd, 1'b1}, "R9 holds asserted after start",
          int'({sr_hold, gate_clr}), int'({1'b1, wd, 1'b1}));
    if (poke) begin
      repeat (30) @(negedge clk);
      // R11: start and new inputs mid-run are ignored
      start = 1'b1; wide_bus = ~wd; dll_tap = ~dll;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    check(done == 1'b1, {tag, " R10 done seen"}, int'(done), 1);
    check(result == exp, {tag, " R1 R6 result word"}, int'(result), int'(exp));
    check(ntr == ent, {tag, " R2 R3 R4 R5 R7 trial count"}, ntr, ent);
    check(sr_hold == 1'b0 && gate_clr == 2'b00, "R9 holds released at done",
          int'({sr_hold, gate_clr}), 0);
    check(hold_bad == 0, "R9 holds during trials", hold_bad, 0);
    if (!wd) check(preset_bad == 0, "R1 idle lane preset", preset_bad, 0);
    @(negedge clk);
    check(done == 1'b0 && result == exp, "R10 done pulse one cycle, result held",
          int'(done), 0);
    if (poke) begin
      extra = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done || trial_req) extra = 1'b1;
      end
      check(!extra, "R11 no queued run after mid-run start", int'(extra), 0);
    end
    wide_bus = 1'b0; dll_tap = 8'h00;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
    $finish;
  end

  initial begin
    int lo;
    void'($urandom(32'd7321));
    rst_n = 1'b0; start = 1'b0; wide_bus = 1'b0; dll_tap = 8'h00;
    trial_ack = 1'b0; trial_fail = 1'b0; tester_on = 1'b1;
    step_g = 8; inv_g = 1'b0; lo_g[0] = 0; hi_g[0] = 255; lo_g[1] = 0; hi_g[1] = 255;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(result == 16'h0 && !done && !trial_req && !sr_hold && gate_clr == 2'b00,
          "R10 reset state", int'({result, done, trial_req, sr_hold, gate_clr}), 0);

    // R4: tap high nibble 0 gives limit 8, coarse-down search skipped
    set_env(8, 1'b0, 40, 140);
    run_cal(1'b0, 8'h00, 1'b0, "R4 skip");
    // R3 R5: reversed fine makes fine seeds fail
    set_env(8, 1'b1, 50, 110);
    run_cal(1'b1, 8'hFF, 1'b0, "R3 R5 seed");
    set_env(16, 1'b1, 60, 200);
    run_cal(1'b0, 8'h35, 1'b0, "R3 R5 wide step");
    // R11 mid-run start
    set_env(8, 1'b0, 30, 120);
    run_cal(1'b1, 8'h42, 1'b1, "R11 busy");
    // R7 both widths, random windows; R6 overflow reached through random sums
    for (int k = 0; k < 60; k++) begin
      int st;
      st = 4 * (1 + int'($urandom % 4));
      lo = int'($urandom % 120);
      set_env(st, 1'($urandom % 2), lo, lo + 10 + int'($urandom % 120));
      run_cal(1'($urandom % 2), 8'($urandom), 1'b0, "R7 random");
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule